// File: doc/BRIEF.md
# Serial ADC Mode and Power Controller

This block is the digital front end of a multichannel serial converter. It watches a chip-select, serial clock and data line. It assembles 8-bit control bytes sent most significant bit first, and from each byte it either changes the operating mode and power state or starts a conversion on one channel. A start of conversion also stores a range code for the addressed channel. The block decides when the input is sampled, and that instant depends on the active mode. It runs a stand-in internal oscillator for acquisition and conversion timing. When a conversion finishes it raises the end-of-conversion strobe.

The serial inputs are sampled on the system clock, and serial clock edges are found by comparing registered copies. The analog converter is modelled by a count of internal oscillator ticks after the sampling instant. Power-down can only be left through a complete, well-formed mode byte, so noise on chip-select cannot wake the block.

Top module: `adc_mode_ctl`

## Requirements
- R1: A frame opens with chip-select low. Bits are taken on rising serial clock edges, most significant bit first, and a byte completes on the 8th falling edge. Bit 7 must be 1 (the start bit), otherwise the frame is ignored. If bit 3 is 1 the byte is a mode byte and its mode code is bits 6:4. If bit 3 is 0 the byte is a start byte: bits 6:4 give the channel and bits 2:0 a range code, which is written to that channel's field `chan_range[3*ch+2:3*ch]`.
- R2: Mode codes 000 (external clock), 001 (external acquisition) and 010 (internal clock) set `mode_o` to that code and `pwr_o` to 00 (full power).
- R3: Mode codes 011 and 101 are ignored: `mode_o` and `pwr_o` stay unchanged.
- R4: Mode code 100 sets `mode_o` to 000 and `pwr_o` to 00, and sets every channel range field to 111 (widest bipolar single-ended).
- R5: Mode code 110 moves the block from full power to partial power-down (`pwr_o` = 01). When the block is in full power-down, this code is ignored.
- R6: Mode code 111 enters full power-down (`pwr_o` = 10) from any power state.
- R7: The block leaves a power-down state only on a complete mode byte. Chip-select toggles, and frames cut short before the 8th falling edge, leave `pwr_o` unchanged.
- R8: While `pwr_o` is not 00, start bytes have no effect: there is no sample, no range write and no strobe.
- R9: In external clock mode, a start byte samples at its own 8th falling serial clock edge.
- R10: In external acquisition mode, sampling happens at the 16th falling serial clock edge of the frame. If chip-select rises before that edge, the conversion is aborted: there is no sample and no strobe.
- R11: In internal clock mode, the oscillator (`osc_en`) starts after the 8th falling edge, and sampling happens on the 11th oscillator tick.
- R12: After sampling, a conversion of CONV_TICKS oscillator ticks runs, each tick being OSC_DIV system clocks. Then `sstrb` goes high.
- R13: `sstrb` goes low on the rising serial clock edge that carries the start bit of the next frame.
- R14: After reset, `mode_o` = 000, `pwr_o` = 00, `sstrb` = 0, `osc_en` = 0, and all range fields are 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| sstrb | output | 1 | End-of-conversion strobe |
| mode_o | output | 3 | Active conversion mode code |
| pwr_o | output | 2 | Power state: 00 full, 01 partial down, 10 full down |
| osc_en | output | 1 | Internal oscillator running |
| sample_pulse | output | 1 | One-cycle pulse at the sampling instant |
| chan_range | output | NCH*3 | Stored range code, 3 bits per channel |

## Verification
Suppose the mode or power register takes a wrong value after a byte. It shows on `mode_o` or `pwr_o` a few system clocks after that byte's 8th falling edge. A wrong sequencer state shows up later. It appears as a missing or extra `sample_pulse` at the mode's clock count, or as `sstrb` rising about CONV_TICKS×OSC_DIV cycles after the sample at the wrong time or not at all. A stuck strobe is seen at the next start bit, when `sstrb` fails to drop.

// File: rtl/adc_mc_pkg.sv
package adc_mc_pkg;

  typedef enum logic [1:0] {
    PWR_FULL    = 2'b00,
    PWR_PARTIAL = 2'b01,
    PWR_DOWN    = 2'b10
  } pwr_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET,
    ACT_RESET,
    ACT_PARTIAL,
    ACT_DOWN
  } act_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT16,
    SEQ_ACQ,
    SEQ_CONV
  } seq_e;

  localparam logic [2:0] MODE_EXTCLK = 3'b000;
  localparam logic [2:0] MODE_EXTACQ = 3'b001;
  localparam logic [2:0] MODE_INTCLK = 3'b010;
  localparam logic [2:0] RANGE_DEFAULT = 3'b111;

  // Map a 3-bit mode code to the action it requests.
  function automatic act_e decode_mode(input logic [2:0] code);
    case (code)
      3'b000, 3'b001, 3'b010: decode_mode = ACT_SET;
      3'b100:                 decode_mode = ACT_RESET;
      3'b110:                 decode_mode = ACT_PARTIAL;
      3'b111:                 decode_mode = ACT_DOWN;
      default:                decode_mode = ACT_NONE;
    endcase
  endfunction

  // Sequencer state entered when a start byte is accepted in a given mode.
  function automatic seq_e first_state(input logic [2:0] mode);
    case (mode)
      MODE_EXTACQ: first_state = SEQ_WAIT16;
      MODE_INTCLK: first_state = SEQ_ACQ;
      default:     first_state = SEQ_CONV;
    endcase
  endfunction

  // Bit 3 of a valid byte set selects a mode byte.
  function automatic logic is_mode_byte(input logic [7:0] b);
    is_mode_byte = b[3];
  endfunction

endpackage

// File: rtl/adc_mc_frame.sv
module adc_mc_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       din,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       start_rise,
  output logic       fall16,
  output logic       cs_rise
);
  localparam int BYTE_BITS = 8;
  localparam int ACQ_FALL  = 16;
  localparam int FCNT_W    = $clog2(ACQ_FALL) + 1;
  localparam int RCNT_W    = $clog2(BYTE_BITS) + 1;

  logic cs_q, cs_qq, sclk_q, sclk_qq, din_q;
  logic [RCNT_W-1:0] rcnt;
  logic [FCNT_W-1:0] fcnt;
  logic [7:0] shreg;
  logic bad;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      cs_qq   <= 1'b1;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      cs_qq   <= cs_q;
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      din_q   <= din;
    end
  end

  assign rise    = sclk_q & ~sclk_qq & ~cs_q;
  assign fall    = ~sclk_q & sclk_qq & ~cs_q;
  assign cs_rise = cs_q & ~cs_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt  <= '0;
      fcnt  <= '0;
      shreg <= '0;
      bad   <= 1'b0;
    end else if (cs_q) begin
      rcnt <= '0;
      fcnt <= '0;
      bad  <= 1'b0;
    end else begin
      if (rise && rcnt < RCNT_W'(BYTE_BITS)) begin
        shreg <= {shreg[6:0], din_q};
        rcnt  <= rcnt + 1'b1;
        if (rcnt == '0 && !din_q) bad <= 1'b1;
      end
      if (fall && fcnt != '1) fcnt <= fcnt + 1'b1;
    end
  end

  assign byte_valid = fall && (fcnt == FCNT_W'(BYTE_BITS - 1)) &&
                      (rcnt == RCNT_W'(BYTE_BITS)) && !bad;
  assign byte_data  = shreg;
  assign start_rise = rise && (rcnt == '0) && din_q;
  assign fall16     = fall && (fcnt == FCNT_W'(ACQ_FALL - 1));

endmodule

// File: rtl/adc_mc_ctl.sv
module adc_mc_ctl
  import adc_mc_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           byte_valid,
  input  logic [7:0]     byte_data,
  input  logic           seq_busy,
  output logic [2:0]     mode_q,
  output pwr_e           pwr_q,
  output logic [NCH*3-1:0] chan_range,
  output logic           conv_start,
  output logic           cfg_reset
);
  act_e act;
  logic mode_byte, cfg_wr;

  assign mode_byte  = byte_valid && is_mode_byte(byte_data);
  assign act        = mode_byte ? decode_mode(byte_data[6:4]) : ACT_NONE;
  assign cfg_reset  = (act == ACT_RESET);
  assign cfg_wr     = byte_valid && !is_mode_byte(byte_data) &&
                      (pwr_q == PWR_FULL) && !seq_busy &&
                      (int'(byte_data[6:4]) < NCH);
  assign conv_start = cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EXTCLK;
      pwr_q  <= PWR_FULL;
    end else begin
      case (act)
        ACT_SET: begin
          mode_q <= byte_data[6:4];
          pwr_q  <= PWR_FULL;
        end
        ACT_RESET: begin
          mode_q <= MODE_EXTCLK;
          pwr_q  <= PWR_FULL;
        end
        ACT_PARTIAL: if (pwr_q == PWR_FULL) pwr_q <= PWR_PARTIAL;
        ACT_DOWN:    pwr_q <= PWR_DOWN;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [2:0] rng_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       rng_q <= RANGE_DEFAULT;
      else if (cfg_reset)                               rng_q <= RANGE_DEFAULT;
      else if (cfg_wr && int'(byte_data[6:4]) == i)     rng_q <= byte_data[2:0];
    end
    assign chan_range[i*3 +: 3] = rng_q;
  end

endmodule

// File: rtl/adc_mc_seq.sv
module adc_mc_seq
  import adc_mc_pkg::*;
#(
  parameter int OSC_DIV    = 4,
  parameter int ACQ_TICKS  = 11,
  parameter int CONV_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start,
  input  logic [2:0] conv_mode,
  input  logic       fall16,
  input  logic       cs_rise,
  input  logic       start_rise,
  output logic       busy,
  output logic       osc_en,
  output logic       sample_pulse,
  output logic       conv_done,
  output logic       sstrb
);
  localparam int MAXT  = (ACQ_TICKS > CONV_TICKS) ? ACQ_TICKS : CONV_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam int DIV_W = $clog2(OSC_DIV + 1);

  seq_e state;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic tick, acq_end, conv_end;

  assign osc_en   = (state == SEQ_ACQ) || (state == SEQ_CONV);
  assign tick     = osc_en && (div == DIV_W'(OSC_DIV - 1));
  assign acq_end  = (state == SEQ_ACQ)  && tick && (cnt == CNT_W'(ACQ_TICKS - 1));
  assign conv_end = (state == SEQ_CONV) && tick && (cnt == CNT_W'(CONV_TICKS - 1));
  assign busy     = (state != SEQ_IDLE);
  assign conv_done = conv_end;

  assign sample_pulse = (state == SEQ_IDLE && conv_start && first_state(conv_mode) == SEQ_CONV) ||
                        (state == SEQ_WAIT16 && fall16) || acq_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div <= '0;
    else if (!osc_en)      div <= '0;
    else if (tick)         div <= '0;
    else                   div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (conv_start) begin
          state <= first_state(conv_mode);
          cnt   <= '0;
        end
        SEQ_WAIT16: begin
          if (fall16)       state <= SEQ_CONV;
          else if (cs_rise) state <= SEQ_IDLE;
        end
        SEQ_ACQ: if (tick) begin
          if (acq_end) begin
            state <= SEQ_CONV;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SEQ_CONV: if (tick) begin
          if (conv_end) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sstrb <= 1'b0;
    else if (conv_done)  sstrb <= 1'b1;
    else if (start_rise) sstrb <= 1'b0;
  end

endmodule

// File: rtl/adc_mode_ctl.sv
module adc_mode_ctl
  import adc_mc_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int OSC_DIV    = 4,
  parameter int ACQ_TICKS  = 11,
  parameter int CONV_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             sstrb,
  output logic [2:0]       mode_o,
  output logic [1:0]       pwr_o,
  output logic             osc_en,
  output logic             sample_pulse,
  output logic [NCH*3-1:0] chan_range
);
  logic       byte_valid, start_rise, fall16, cs_rise;
  logic [7:0] byte_data;
  logic       seq_busy, conv_start, conv_done, cfg_reset;
  logic [2:0] mode_q;
  pwr_e       pwr_q;

  adc_mc_frame frame_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .start_rise(start_rise), .fall16(fall16), .cs_rise(cs_rise)
  );

  adc_mc_ctl #(.NCH(NCH)) ctl_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .seq_busy(seq_busy), .mode_q(mode_q), .pwr_q(pwr_q),
    .chan_range(chan_range), .conv_start(conv_start), .cfg_reset(cfg_reset)
  );

  adc_mc_seq #(.OSC_DIV(OSC_DIV), .ACQ_TICKS(ACQ_TICKS), .CONV_TICKS(CONV_TICKS)) seq_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_mode(mode_q),
    .fall16(fall16), .cs_rise(cs_rise), .start_rise(start_rise),
    .busy(seq_busy), .osc_en(osc_en), .sample_pulse(sample_pulse),
    .conv_done(conv_done), .sstrb(sstrb)
  );

  assign mode_o = mode_q;
  assign pwr_o  = pwr_q;

endmodule

// File: rtl/adc_mc_chk.sv
module adc_mc_chk #(
  parameter int NCH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic [7:0]       byte_data,
  input logic             start_rise,
  input logic             conv_start,
  input logic             conv_done,
  input logic             sample_pulse,
  input logic             sstrb,
  input logic             osc_en,
  input logic [2:0]       mode_o,
  input logic [1:0]       pwr_o,
  input logic [NCH*3-1:0] chan_range
);
  // R12
  strobe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> $past(conv_done));

  // R13
  strobe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sstrb) |-> $past(start_rise));

  // R8
  pd_no_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_o != 2'b00) |-> !conv_start);

  // R3
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_data[3] && (byte_data[6:4] == 3'b011 || byte_data[6:4] == 3'b101))
    |=> ($stable(mode_o) && $stable(pwr_o)));

  // R7
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_o != 2'b00) |=> ((pwr_o != 2'b00) || $past(byte_valid)));

  // R4
  reset_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_data[3] && byte_data[6:4] == 3'b100)
    |=> (mode_o == 3'b000 && pwr_o == 2'b00 && (&chan_range)));

  // R12
  sample_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> osc_en);

endmodule

bind adc_mode_ctl adc_mc_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
  .start_rise(start_rise), .conv_start(conv_start), .conv_done(conv_done),
  .sample_pulse(sample_pulse), .sstrb(sstrb), .osc_en(osc_en),
  .mode_o(mode_o), .pwr_o(pwr_o), .chan_range(chan_range)
);

// File: tb/adc_mode_ctl_tb.sv
`timescale 1ns/1ps
module adc_mode_ctl_tb_top;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic sstrb, osc_en, sample_pulse;
  logic [2:0] mode_o;
  logic [1:0] pwr_o;
  logic [NCH*3-1:0] chan_range;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_mode_ctl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sstrb(sstrb), .mode_o(mode_o), .pwr_o(pwr_o), .osc_en(osc_en),
    .sample_pulse(sample_pulse), .chan_range(chan_range)
  );

  // Observation counters built from port activity only
  int samp_cnt = 0, oscrun = 0, acq_len = -1, since_samp = 0, conv_len = -1;
  bit counting = 1'b0, sstrb_d = 1'b0;
  always @(posedge clk) begin
    if (!osc_en) oscrun <= 0; else oscrun <= oscrun + 1;
    if (sample_pulse) begin
      samp_cnt   <= samp_cnt + 1;
      acq_len    <= oscrun;
      since_samp <= 0;
      counting   <= 1'b1;
    end else if (counting) since_samp <= since_samp + 1;
    if (sstrb && !sstrb_d && counting) begin
      conv_len <= since_samp;
      counting <= 1'b0;
    end
    sstrb_d <= sstrb;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int nclk);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nclk; i++) begin
      din = (i < 8) ? b[7-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    din  = 1'b0;
    wait_clk(200);
  endtask

  typedef struct packed {
    logic [7:0] b;
    logic [4:0] n;
    logic [2:0] m;
    logic [1:0] p;
    logic       s;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h98, 5'd8,  3'd1, 2'd0, 1'b0},  // R2 ext acquisition
    '{8'hA5, 5'd16, 3'd1, 2'd0, 1'b1},  // R10 R12 sample at 16th fall
    '{8'hA8, 5'd8,  3'd2, 2'd0, 1'b0},  // R2 R13 internal clock, strobe cleared
    '{8'h80, 5'd8,  3'd2, 2'd0, 1'b1},  // R11 R12 internal conversion
    '{8'hB8, 5'd8,  3'd2, 2'd0, 1'b0},  // R3 reserved 011, R13 strobe cleared
    '{8'hE8, 5'd8,  3'd2, 2'd1, 1'b0},  // R5 partial power-down
    '{8'h80, 5'd8,  3'd2, 2'd1, 1'b0},  // R8 start byte ignored
    '{8'h78, 5'd8,  3'd2, 2'd1, 1'b0},  // R1 no start bit, ignored
    '{8'hF8, 5'd8,  3'd2, 2'd2, 1'b0},  // R6 R7 full power-down
    '{8'hE8, 5'd8,  3'd2, 2'd2, 1'b0},  // R5 partial ignored in full down
    '{8'hD8, 5'd8,  3'd2, 2'd2, 1'b0},  // R3 reserved 101
    '{8'h88, 5'd8,  3'd0, 2'd0, 1'b0},  // R7 R2 exit to ext clock
    '{8'h80, 5'd8,  3'd0, 2'd0, 1'b1},  // R9 ext clock conversion
    '{8'hC8, 5'd8,  3'd0, 2'd0, 1'b0}   // R4 reset byte
  };

  initial begin
    int s0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R14 reset state
    chk("R14 mode", int'(mode_o), 0);
    chk("R14 pwr", int'(pwr_o), 0);
    chk("R14 sstrb", int'(sstrb), 0);
    chk("R14 osc_en", int'(osc_en), 0);
    chk("R14 ranges", int'(&chan_range), 1);

    for (int k = 0; k < NV; k++) begin
      send(VECS[k].b, int'(VECS[k].n));
      chk($sformatf("vector %0d mode", k), int'(mode_o), int'(VECS[k].m));
      chk($sformatf("vector %0d pwr", k), int'(pwr_o), int'(VECS[k].p));
      chk($sformatf("vector %0d sstrb", k), int'(sstrb), int'(VECS[k].s));
    end

    // R4 ranges restored after reset byte
    chk("R4 ranges default", int'(&chan_range), 1);

    // R1 R9 ext clock start byte writes range, one sample
    s0 = samp_cnt;
    send(8'hA5, 8);
    chk("R1 ch2 range", int'(chan_range[8:6]), 5);
    chk("R9 sample count", samp_cnt - s0, 1);
    chk("R9 sstrb", int'(sstrb), 1);

    // R10 ext acquisition aborted by early chip-select rise
    send(8'h98, 8);
    s0 = samp_cnt;
    send(8'hA5, 12);
    chk("R10 abort no sample", samp_cnt - s0, 0);
    chk("R10 abort no strobe", int'(sstrb), 0);
    chk("R10 abort osc off", int'(osc_en), 0);

    // R11 R12 internal clock timing
    send(8'hA8, 8);
    send(8'h80, 8);
    chk_win("R11 ticks to sample", acq_len, 40, 48);
    chk_win("R12 conversion length", conv_len, 76, 84);
    chk("R12 sstrb", int'(sstrb), 1);

    // R7 R8 partial power-down robustness
    send(8'hE8, 8);
    chk("R5 partial", int'(pwr_o), 1);
    cs_n = 1'b0; wait_clk(10); cs_n = 1'b1; wait_clk(20);
    chk("R7 cs glitch", int'(pwr_o), 1);
    send(8'h88, 5);
    chk("R7 short frame", int'(pwr_o), 1);
    s0 = samp_cnt;
    send(8'h81, 8);
    chk("R8 range kept", int'(chan_range[2:0]), 0);
    chk("R8 no sample", samp_cnt - s0, 0);
    send(8'h88, 8);
    chk("R7 exit", int'(pwr_o), 0);
    chk("R2 mode ext clock", int'(mode_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule